// File: doc/BRIEF.md
# Register Block Transfer Sequencer

This block moves a contiguous run of 32-bit general registers to or from a byte-addressed memory. A command names a first register, a start address, a direction (load or store), a byte order and one of two shapes. A "multiple" command covers every register from the first one through the highest register. A "string" command covers a byte count: full words first, then one to three leftover bytes packed into one last register. The block issues one memory access at a time on a valid/ready request channel and takes the reply on a valid/ready response channel. It reads and writes the register file through a plain combinational read port and a write strobe.

Every request, load or store, gets exactly one response. The request channel obeys back-pressure: while `mreq_valid` is high and `mreq_ready` is low, the block holds the address, data, direction and size unchanged. The response channel is ready only while the block waits for a reply. A word on the bus carries the byte at the lowest address in bits 31:24. A single-byte access carries its byte in bits 7:0, and its store data has bits 31:8 at zero.

Top module: `strmw_seq`

## Requirements
- R1: A multiple command moves one word per register, from the first register through register 31 inclusive, and the address rises by 4 after each word. Load data reaches the register file only in the cycle in which a response is accepted.
- R2: A string command moves full words while 4 or more bytes remain, and each word lowers the count by 4 and raises the address by 4.
- R3: In a string command the register index rises after each full word and wraps from 31 to 0.
- R4: When 1 to 3 bytes remain, each is moved by its own single-byte access (`mreq_byte` = 1), and the address rises by 1 per byte. A string of N bytes issues floor(N/4) + (N mod 4) requests.
- R5: Tail bytes take register bits 31:24, then 23:16, then 15:8 in big-endian mode (`cmd_le` = 0). In little-endian mode (`cmd_le` = 1) they take bits 7:0, then 15:8, then 23:16.
- R6: In little-endian mode every full word is byte-reversed on both loads and stores: register bits 7:0 pair with the bus bits 31:24.
- R7: A tail store sends (register >> bit position) & 0xFF on `mreq_wdata[7:0]`, with bits 31:8 at zero.
- R8: On a string load with a tail, the bits of the last register that receive no byte are written as zero.
- R9: A string command with a byte count of 0 issues no request, and `done` is high for exactly one cycle, in the cycle after the start.
- R10: `busy` is high from the accepted start until the last response is accepted. A start is taken only while `busy` and `done` are both low, and all other starts are ignored.
- R11: While a request is stalled by `mreq_ready` = 0, the request stays valid with its address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command strobe, taken when idle |
| cmd_string | input | 1 | 1 = string command, 0 = multiple command |
| cmd_store | input | 1 | 1 = store registers to memory, 0 = load |
| cmd_le | input | 1 | 1 = little-endian (byte-reversed) mode |
| cmd_reg | input | 5 | First register index |
| cmd_addr | input | 32 | Start byte address |
| cmd_nbytes | input | 8 | Byte count for string commands |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| mreq_valid | output | 1 | Memory request valid |
| mreq_ready | input | 1 | Memory accepts the request |
| mreq_write | output | 1 | Request is a store |
| mreq_byte | output | 1 | Request is a single-byte access |
| mreq_addr | output | 32 | Request byte address |
| mreq_wdata | output | 32 | Store data |
| mrsp_valid | input | 1 | Memory response valid |
| mrsp_ready | output | 1 | Block accepts the response |
| mrsp_rdata | input | 32 | Load data |
| rf_rd_idx | output | 5 | Register file read index |
| rf_rd_data | input | 32 | Register file read data, same cycle |
| rf_we | output | 1 | Register file write strobe |
| rf_wr_idx | output | 5 | Register file write index |
| rf_wr_data | output | 32 | Register file write data |

## Verification
A zero-count string raises `done` in the first cycle after the start edge, so the bench samples `done` at the falling edge that follows that edge, and again one cycle later to see it drop. Any other command finishes in the cycle after its final response is accepted. Register writes land on that same response edge, so the bench waits for `done` at falling edges and only then compares the register file and the memory image against a byte-level model. The memory model stalls `mreq_ready` on a fixed pattern and answers one cycle after each handshake. This makes every command run through back-pressure, and the bench also counts the handshakes for each command.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RSP  = 2'd2,
    ST_FIN  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/lsm_byterev.sv
module lsm_byterev #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  localparam int NB = DW / 8;
  for (genvar gi = 0; gi < NB; gi++) begin : g_lane
    assign dout[8*gi +: 8] = din[8*(NB-1-gi) +: 8];
  end
endmodule

// File: rtl/lsm_lane.sv
module lsm_lane #(
  parameter int DW = 32,
  parameter int LW = 2
) (
  input  logic [LW-1:0] lane,
  input  logic [DW-1:0] acc,
  input  logic [7:0]    rbyte,
  input  logic [DW-1:0] src,
  output logic [DW-1:0] merged,
  output logic [7:0]    picked
);
  logic [LW+2:0] bitpos;
  assign bitpos = {lane, 3'b000};
  assign merged = acc | (DW'(rbyte) << bitpos);
  assign picked = src[bitpos +: 8];
endmodule

// File: rtl/strmw_seq.sv
module strmw_seq #(
  parameter int AW = 32,
  parameter int CW = 8,
  parameter int RW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cmd_string,
  input  logic          cmd_store,
  input  logic          cmd_le,
  input  logic [RW-1:0] cmd_reg,
  input  logic [AW-1:0] cmd_addr,
  input  logic [CW-1:0] cmd_nbytes,
  output logic          busy,
  output logic          done,
  output logic          mreq_valid,
  input  logic          mreq_ready,
  output logic          mreq_write,
  output logic          mreq_byte,
  output logic [AW-1:0] mreq_addr,
  output logic [DW-1:0] mreq_wdata,
  input  logic          mrsp_valid,
  output logic          mrsp_ready,
  input  logic [DW-1:0] mrsp_rdata,
  output logic [RW-1:0] rf_rd_idx,
  input  logic [DW-1:0] rf_rd_data,
  output logic          rf_we,
  output logic [RW-1:0] rf_wr_idx,
  output logic [DW-1:0] rf_wr_data
);
  import lsm_pkg::*;

  localparam int NBYTE = DW / 8;
  localparam int LW = $clog2(NBYTE);
  localparam logic [RW-1:0] LAST_REG = {RW{1'b1}};

  seq_state_t    state_q;
  logic [RW-1:0] reg_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic [LW-1:0] lane_q;
  logic [DW-1:0] acc_q;
  logic          str_q, st_q, le_q;

  logic          word_acc, rsp_fire, last_word;
  logic [DW-1:0] ld_rev, st_rev, merged;
  logic [7:0]    picked;
  logic [LW-1:0] lane_nx;

  lsm_byterev #(.DW(DW)) u_rev_ld (.din(mrsp_rdata), .dout(ld_rev));
  lsm_byterev #(.DW(DW)) u_rev_st (.din(rf_rd_data), .dout(st_rev));

  lsm_lane #(.DW(DW), .LW(LW)) u_lane (
    .lane   (lane_q),
    .acc    (acc_q),
    .rbyte  (mrsp_rdata[7:0]),
    .src    (rf_rd_data),
    .merged (merged),
    .picked (picked)
  );

  assign word_acc  = !str_q || (cnt_q >= CW'(NBYTE));
  assign rsp_fire  = (state_q == ST_RSP) && mrsp_valid;
  assign last_word = str_q ? (cnt_q == CW'(NBYTE)) : (reg_q == LAST_REG);
  assign lane_nx   = le_q ? lane_q + LW'(1) : lane_q - LW'(1);

  assign busy       = (state_q == ST_REQ) || (state_q == ST_RSP);
  assign done       = (state_q == ST_FIN);
  assign mreq_valid = (state_q == ST_REQ);
  assign mreq_write = st_q;
  assign mreq_byte  = !word_acc;
  assign mreq_addr  = addr_q;
  assign mreq_wdata = word_acc ? (le_q ? st_rev : rf_rd_data) : DW'(picked);
  assign mrsp_ready = (state_q == ST_RSP);

  assign rf_rd_idx  = reg_q;
  assign rf_wr_idx  = reg_q;
  assign rf_we      = rsp_fire && !st_q && (word_acc || cnt_q == CW'(1));
  assign rf_wr_data = word_acc ? (le_q ? ld_rev : mrsp_rdata) : merged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      reg_q   <= '0;
      addr_q  <= '0;
      cnt_q   <= '0;
      lane_q  <= '0;
      acc_q   <= '0;
      str_q   <= 1'b0;
      st_q    <= 1'b0;
      le_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          reg_q   <= cmd_reg;
          addr_q  <= cmd_addr;
          cnt_q   <= cmd_nbytes;
          lane_q  <= cmd_le ? '0 : '1;
          acc_q   <= '0;
          str_q   <= cmd_string;
          st_q    <= cmd_store;
          le_q    <= cmd_le;
          state_q <= (cmd_string && cmd_nbytes == '0) ? ST_FIN : ST_REQ;
        end
        ST_REQ: if (mreq_ready) state_q <= ST_RSP;
        ST_RSP: if (mrsp_valid) begin
          if (word_acc) begin
            addr_q  <= addr_q + AW'(NBYTE);
            reg_q   <= reg_q + RW'(1);
            if (str_q) cnt_q <= cnt_q - CW'(NBYTE);
            state_q <= last_word ? ST_FIN : ST_REQ;
          end else begin
            addr_q  <= addr_q + AW'(1);
            cnt_q   <= cnt_q - CW'(1);
            lane_q  <= lane_nx;
            acc_q   <= merged;
            state_q <= (cnt_q == CW'(1)) ? ST_FIN : ST_REQ;
          end
        end
        ST_FIN: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lsm_seq_chk.sv
module lsm_seq_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          mreq_valid,
  input logic          mreq_ready,
  input logic          mreq_write,
  input logic          mreq_byte,
  input logic [AW-1:0] mreq_addr,
  input logic [DW-1:0] mreq_wdata,
  input logic          mrsp_valid,
  input logic          mrsp_ready,
  input logic          rf_we
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && !mreq_ready |=> mreq_valid && $stable(mreq_addr)); // R11
  AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid |-> busy); // R10
  AST_RSP_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mrsp_ready |-> busy && !done); // R10
  AST_WRITE_ON_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> mrsp_valid && mrsp_ready); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_TAIL_STORE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && mreq_byte && mreq_write |-> mreq_wdata[DW-1:8] == '0); // R7
endmodule

bind strmw_seq lsm_seq_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_write(mreq_write),
  .mreq_byte(mreq_byte), .mreq_addr(mreq_addr), .mreq_wdata(mreq_wdata),
  .mrsp_valid(mrsp_valid), .mrsp_ready(mrsp_ready), .rf_we(rf_we)
);

// File: tb/strmw_seq_tb_top.sv
`timescale 1ns/1ps
module strmw_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        start = 0, cmd_string = 0, cmd_store = 0, cmd_le = 0;
  logic [4:0]  cmd_reg = 0;
  logic [31:0] cmd_addr = 0;
  logic [7:0]  cmd_nbytes = 0;
  logic        busy, done, mreq_valid, mreq_write, mreq_byte, mrsp_ready, rf_we;
  logic        mreq_ready = 0, mrsp_valid = 0;
  logic [31:0] mreq_addr, mreq_wdata, rf_wr_data, rf_rd_data;
  logic [31:0] mrsp_rdata = 0;
  logic [4:0]  rf_rd_idx, rf_wr_idx;

  logic [7:0]  mem [0:255];
  logic [31:0] rf [0:31];
  logic [7:0]  ref_mem [0:255];
  logic [31:0] ref_rf [0:31];
  int          n_req = 0;
  logic [2:0]  stall = 0;
  int          errors = 0, checks = 0;

  strmw_seq dut_i (
    .clk, .rst_n, .start, .cmd_string, .cmd_store, .cmd_le, .cmd_reg,
    .cmd_addr, .cmd_nbytes, .busy, .done, .mreq_valid, .mreq_ready,
    .mreq_write, .mreq_byte, .mreq_addr, .mreq_wdata, .mrsp_valid,
    .mrsp_ready, .mrsp_rdata, .rf_rd_idx, .rf_rd_data, .rf_we,
    .rf_wr_idx, .rf_wr_data
  );

  assign rf_rd_data = rf[rf_rd_idx];

  always @(posedge clk) begin
    if (rf_we) rf[rf_wr_idx] <= rf_wr_data;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mrsp_valid <= 0;
      mreq_ready <= 0;
      stall <= 0;
    end else begin
      stall <= stall + 1;
      mreq_ready <= (stall != 3'd2) && (stall != 3'd5);
      if (mrsp_valid && mrsp_ready) mrsp_valid <= 0;
      if (mreq_valid && mreq_ready) begin
        n_req <= n_req + 1;
        mrsp_valid <= 1;
        if (mreq_write) begin
          if (mreq_byte) mem[mreq_addr[7:0]] <= mreq_wdata[7:0];
          else begin
            mem[mreq_addr[7:0]]        <= mreq_wdata[31:24];
            mem[8'(mreq_addr[7:0] + 1)] <= mreq_wdata[23:16];
            mem[8'(mreq_addr[7:0] + 2)] <= mreq_wdata[15:8];
            mem[8'(mreq_addr[7:0] + 3)] <= mreq_wdata[7:0];
          end
        end else if (mreq_byte) mrsp_rdata <= {24'h0, mem[mreq_addr[7:0]]};
        else mrsp_rdata <= {mem[mreq_addr[7:0]], mem[8'(mreq_addr[7:0] + 1)],
                            mem[8'(mreq_addr[7:0] + 2)], mem[8'(mreq_addr[7:0] + 3)]};
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + seed);
    for (int k = 0; k < 32; k++) rf[k] = 32'h5A000000 | (k << 16) | ((k * 13 + seed) & 16'hFFFF);
  endtask

  task automatic ref_byte(input bit st, input int k, input int a, input int pos);
    if (st) ref_mem[a & 255] = ref_rf[k][pos +: 8];
    else ref_rf[k][pos +: 8] = ref_mem[a & 255];
  endtask

  task automatic ref_run(input bit str, input bit st, input bit le,
                         input int r, input int a0, input int n);
    int a = a0;
    int k = r;
    int left = n;
    for (int i = 0; i < 256; i++) ref_mem[i] = mem[i];
    for (int j = 0; j < 32; j++) ref_rf[j] = rf[j];
    if (!str) begin
      for (int kk = r; kk < 32; kk++) begin
        for (int b = 0; b < 4; b++) ref_byte(st, kk, a + b, le ? 8 * b : 24 - 8 * b);
        a += 4;
      end
    end else begin
      while (left >= 4) begin
        for (int b = 0; b < 4; b++) ref_byte(st, k, a + b, le ? 8 * b : 24 - 8 * b);
        a += 4; left -= 4; k = (k + 1) % 32;
      end
      if (left > 0) begin
        if (!st) ref_rf[k] = 0;
        for (int b = 0; b < left; b++) ref_byte(st, k, a + b, le ? 8 * b : 24 - 8 * b);
      end
    end
  endtask

  task automatic issue(input bit str, input bit st, input bit le,
                       input int r, input int a, input int n);
    @(negedge clk);
    start = 1; cmd_string = str; cmd_store = st; cmd_le = le;
    cmd_reg = 5'(r); cmd_addr = 32'(a); cmd_nbytes = 8'(n);
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done(input string req);
    int g = 0;
    while (!done && g < 2000) begin @(negedge clk); g++; end
    check(done, req, "done seen", 32'(done), 1);
  endtask

  task automatic compare(input string req);
    int bad = 0;
    int first = -1;
    for (int k = 0; k < 32; k++)
      check(rf[k] === ref_rf[k], req, $sformatf("reg %0d", k), rf[k], ref_rf[k]);
    for (int i = 0; i < 256; i++)
      if (mem[i] !== ref_mem[i]) begin bad++; if (first < 0) first = i; end
    if (first < 0) check(1, req, "memory image", 0, 0);
    else check(0, req, $sformatf("memory byte %0d", first), 32'(mem[first]), 32'(ref_mem[first]));
  endtask

  task automatic run_cmd(input string req, input bit str, input bit st, input bit le,
                         input int r, input int a, input int n, input int exp_req);
    int n0;
    ref_run(str, st, le, r, a, n);
    n0 = n_req;
    issue(str, st, le, r, a, n);
    wait_done(req);
    @(negedge clk);
    check(!busy && !done, req, "idle after done", {busy, done}, 0);
    compare(req);
    check(n_req - n0 == exp_req, req, "request count", 32'(n_req - n0), 32'(exp_req));
  endtask

  task automatic t_reset;
    check(!busy && !done && !mreq_valid && !rf_we, "R10", "reset state",
          {busy, done, mreq_valid, rf_we}, 0);
  endtask

  task automatic t_load_multiple;  fill(3); run_cmd("R1", 0, 0, 0, 28, 16, 0, 4); endtask
  task automatic t_store_mult_le;  fill(9); run_cmd("R1 R6", 0, 1, 1, 30, 64, 0, 2); endtask
  task automatic t_str_load_be;    fill(5); run_cmd("R2 R3 R4 R5 R8", 1, 0, 0, 30, 100, 11, 5); endtask
  task automatic t_str_load_le;    fill(11); run_cmd("R5 R6 R8", 1, 0, 1, 5, 40, 6, 3); endtask
  task automatic t_str_store_be;   fill(2); run_cmd("R3 R7", 1, 1, 0, 31, 140, 7, 4); endtask
  task automatic t_str_store_le;   fill(4); run_cmd("R4 R7", 1, 1, 1, 9, 201, 3, 3); endtask
  task automatic t_str_exact;      fill(6); run_cmd("R2", 1, 0, 0, 2, 8, 8, 2); endtask

  task automatic t_zero_count;
    int n0 = n_req;
    fill(1);
    issue(1, 0, 0, 4, 20, 0);
    check(done === 1'b1, "R9", "done one cycle after start", 32'(done), 1);
    check(!busy && !mreq_valid, "R9", "no request", {busy, mreq_valid}, 0);
    @(negedge clk);
    check(done === 1'b0, "R9", "done single cycle", 32'(done), 0);
    check(n_req == n0, "R9", "zero requests", 32'(n_req - n0), 0);
  endtask

  task automatic t_ignore_busy;
    int n0;
    fill(8);
    ref_run(0, 0, 0, 29, 48, 0);
    n0 = n_req;
    issue(0, 0, 0, 29, 48, 0);
    @(negedge clk);
    check(busy === 1'b1, "R10", "busy during command", 32'(busy), 1);
    start = 1; cmd_string = 0; cmd_store = 1; cmd_reg = 0; cmd_addr = 128;
    @(negedge clk);
    start = 0;
    wait_done("R10");
    @(negedge clk);
    check(!busy, "R10", "second start not taken", 32'(busy), 0);
    compare("R10");
    check(n_req - n0 == 3, "R10", "request count", 32'(n_req - n0), 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    fill(0);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_load_multiple();
    t_store_mult_le();
    t_str_load_be();
    t_str_load_le();
    t_str_store_be();
    t_str_store_le();
    t_str_exact();
    t_zero_count();
    t_ignore_busy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule